// File: doc/BRIEF.md
# Banked Replicated On-Chip Memory

This block is a parameterised on-chip RAM split into a power-of-two number of banks. A mask parameter picks which address bits choose the bank. Those bits may sit at any positions in the address. The bits left over form the row inside the bank, kept in their original order. Each bank keeps several replicates, which are identical copies of its contents. Every write updates all replicates of the target bank, so each replicate can serve reads on its own and the bank gains read ports.

There are several read ports and one write port. In each cycle the block arbitrates the reads that land on each bank against the physical ports that bank has free. Reads that fit return data one clock later with a valid flag. Reads that do not fit are dropped, and a contention flag reports them in the same cycle the results are due. A parameter chooses between two port modes. In true dual port mode each replicate port may read or write. In simple dual port mode one port of each replicate is reserved for writes.

Top module: `banked_repl_mem`

## Requirements
- R1: The bank number is made of the address bits set in `SEL_MASK`, and the lowest set position gives the bank LSB. With the default mask `6'b010010`, bank = {addr[4], addr[1]}, so there are four banks.
- R2: The row is the address with the bank bits removed, the remaining bits kept in order. Each of the 2^ADDR_W addresses maps to its own storage word.
- R3: For a granted read, `rd_valid[p]` is high and `rd_data[p]` holds the word, one clock after the address is sampled. `rd_valid[p]` is never high unless `rd_en[p]` was high in the previous cycle.
- R4: When a read and a write hit the same address in the same cycle, the read returns the value stored before the write.
- R5: A write updates every replicate of its bank. A read served by any replicate in a later cycle returns the new value.
- R6: In true dual port mode, each replicate offers two ports. A bank with no write in the cycle serves up to 2*REPL reads. A bank that is being written serves REPL reads.
- R7: In simple dual port mode, a bank serves at most REPL reads per cycle, whether or not it is being written.
- R8: Within a bank, reads are granted in ascending port index. A read that loses gets `rd_valid[p]` low in the result cycle.
- R9: `conflict` is high in a result cycle exactly when at least one enabled read from the previous cycle was dropped.
- R10: Synchronous reset clears `rd_valid` and `conflict` but leaves the stored words unchanged.
- R11: A write is always performed, whatever the read load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | NUM_RD | Read request per port |
| rd_addr | input | NUM_RD x ADDR_W | Read address per port |
| rd_valid | output | NUM_RD | Read result valid per port, one cycle after the request |
| rd_data | output | NUM_RD x DATA_W | Read data per port |
| conflict | output | 1 | High when reads of the previous cycle were dropped |

## Verification
Every result (`rd_valid`, `rd_data` and `conflict`) is due exactly one clock edge after the inputs are sampled. There is one register on the path, and the write takes effect at that same edge. The bench drives each stimulus on a falling edge and lets one rising edge pass. It checks at the following falling edge against a shadow memory. The write of that cycle is folded into the shadow only after the comparison, so same-cycle reads are expected to return old data. A second instance in simple dual port mode receives the same stimulus, and the bench computes the expected grants for each mode from the per-bank capacity rules.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

    typedef enum logic {
        PORTS_TRUE_DUAL   = 1'b0,
        PORTS_SIMPLE_DUAL = 1'b1
    } port_mode_e;

    function automatic int unsigned count_ones(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) n++;
        end
        return n;
    endfunction

    // Reads a bank can accept in one cycle given its write activity.
    function automatic int unsigned read_capacity(input port_mode_e mode,
                                                  input int unsigned repl,
                                                  input logic wr_hit);
        if (mode == PORTS_SIMPLE_DUAL) return repl;
        if (wr_hit) return repl;
        return 2 * repl;
    endfunction

    // True when two reads share one replicate (both ports used for reads).
    function automatic logic pair_reads(input port_mode_e mode, input logic wr_hit);
        return (mode == PORTS_TRUE_DUAL) && !wr_hit;
    endfunction

endpackage

// File: rtl/bmem_addr_split.sv
module bmem_addr_split #(
    parameter int unsigned ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] SEL_MASK = 6'b010010,
    parameter int unsigned BANK_W   = 2,
    parameter int unsigned ROW_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);
    int unsigned bi;
    int unsigned ri;

    always_comb begin
        bank = '0;
        row  = '0;
        bi   = 0;
        ri   = 0;
        for (int i = 0; i < int'(ADDR_W); i++) begin
            if (SEL_MASK[i]) begin
                if (bi < BANK_W) bank[bi] = addr[i];
                bi++;
            end else begin
                if (ri < ROW_W) row[ri] = addr[i];
                ri++;
            end
        end
    end
endmodule

// File: rtl/bmem_arbiter.sv
module bmem_arbiter
    import bmem_pkg::*;
#(
    parameter int unsigned NUM_RD = 4,
    parameter int unsigned REPL   = 2,
    parameter port_mode_e  MODE   = PORTS_TRUE_DUAL,
    parameter int unsigned RSEL_W = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_RD-1:0]              req,
    input  logic                           wr_hit,
    output logic [NUM_RD-1:0]              grant,
    output logic [NUM_RD-1:0][RSEL_W-1:0]  repl_sel
);
    int unsigned cap;
    int unsigned taken;
    logic        paired;

    always_comb begin
        cap    = read_capacity(MODE, REPL, wr_hit);
        paired = pair_reads(MODE, wr_hit);
        taken  = 0;
        grant  = '0;
        for (int p = 0; p < int'(NUM_RD); p++) begin
            repl_sel[p] = '0;
            if (req[p] && taken < cap) begin
                grant[p]    = 1'b1;
                repl_sel[p] = paired ? RSEL_W'(taken / 2) : RSEL_W'(taken);
                taken++;
            end
        end
    end

    logic [NUM_RD-1:0] lost;
    logic [NUM_RD-1:0] first_lost;
    assign lost       = req & ~grant;
    assign first_lost = lost & (~lost + NUM_RD'(1));

    // R8
    priority_order_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~(first_lost - NUM_RD'(1))) == '0);

    // R6
    grant_capacity_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= read_capacity(MODE, REPL, wr_hit));

    // R7
    simple_dual_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (MODE == PORTS_SIMPLE_DUAL) |-> $countones(grant) <= REPL);
endmodule

// File: rtl/bmem_bank.sv
module bmem_bank #(
    parameter int unsigned NUM_RD = 4,
    parameter int unsigned REPL   = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROW_W  = 4,
    parameter int unsigned RSEL_W = 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ROW_W-1:0]               wr_row,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_RD-1:0]              rd_en,
    input  logic [NUM_RD-1:0][ROW_W-1:0]   rd_row,
    input  logic [NUM_RD-1:0][RSEL_W-1:0]  rd_repl,
    output logic [NUM_RD-1:0][DATA_W-1:0]  rd_q
);
    localparam int unsigned ROWS = 1 << ROW_W;

    logic [DATA_W-1:0] mem [REPL][ROWS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int r = 0; r < int'(REPL); r++) begin
                mem[r][wr_row] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < int'(NUM_RD); p++) begin
            if (rd_en[p]) rd_q[p] <= mem[rd_repl[p]][rd_row[p]];
        end
    end

    // R5
    replicas_agree_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> mem[0][$past(wr_row)] == mem[REPL-1][$past(wr_row)]);

    // R11
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en) |-> mem[0][$past(wr_row)] == $past(wr_data));
endmodule

// File: rtl/banked_repl_mem.sv
module banked_repl_mem
    import bmem_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 6,
    parameter int unsigned       DATA_W    = 8,
    parameter logic [ADDR_W-1:0] SEL_MASK  = 6'b010010,
    parameter int unsigned       NUM_RD    = 4,
    parameter int unsigned       REPL      = 2,
    parameter port_mode_e        PORT_MODE = PORTS_TRUE_DUAL
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_RD-1:0]             rd_en,
    input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
    output logic [NUM_RD-1:0]             rd_valid,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
    output logic                          conflict
);
    localparam int unsigned BANK_W    = count_ones(32'(SEL_MASK));
    localparam int unsigned NUM_BANKS = 1 << BANK_W;
    localparam int unsigned ROW_W     = ADDR_W - BANK_W;
    localparam int unsigned RSEL_W    = (REPL > 1) ? $clog2(REPL) : 1;

    logic [BANK_W-1:0] wr_bank;
    logic [ROW_W-1:0]  wr_row;
    logic [NUM_RD-1:0][BANK_W-1:0] rd_bank;
    logic [NUM_RD-1:0][ROW_W-1:0]  rd_row;

    bmem_addr_split #(
        .ADDR_W(ADDR_W), .SEL_MASK(SEL_MASK), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_wr_split (
        .addr(wr_addr), .bank(wr_bank), .row(wr_row)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd_split
        bmem_addr_split #(
            .ADDR_W(ADDR_W), .SEL_MASK(SEL_MASK), .BANK_W(BANK_W), .ROW_W(ROW_W)
        ) u_split (
            .addr(rd_addr[p]), .bank(rd_bank[p]), .row(rd_row[p])
        );
    end

    logic [NUM_RD-1:0]                  bank_req   [NUM_BANKS];
    logic [NUM_RD-1:0]                  bank_grant [NUM_BANKS];
    logic [NUM_RD-1:0][RSEL_W-1:0]      bank_repl  [NUM_BANKS];
    logic [NUM_RD-1:0][DATA_W-1:0]      bank_q     [NUM_BANKS];
    logic [NUM_BANKS-1:0]               wr_hit;
    logic [NUM_RD-1:0]                  granted;

    always_comb begin
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            wr_hit[b] = wr_en && (wr_bank == BANK_W'(b));
            for (int p = 0; p < int'(NUM_RD); p++) begin
                bank_req[b][p] = rd_en[p] && (rd_bank[p] == BANK_W'(b));
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bmem_arbiter #(
            .NUM_RD(NUM_RD), .REPL(REPL), .MODE(PORT_MODE), .RSEL_W(RSEL_W)
        ) u_arb (
            .clk(clk), .rst(rst),
            .req(bank_req[b]), .wr_hit(wr_hit[b]),
            .grant(bank_grant[b]), .repl_sel(bank_repl[b])
        );

        bmem_bank #(
            .NUM_RD(NUM_RD), .REPL(REPL), .DATA_W(DATA_W),
            .ROW_W(ROW_W), .RSEL_W(RSEL_W)
        ) u_bank (
            .clk(clk), .rst(rst),
            .wr_en(wr_hit[b]), .wr_row(wr_row), .wr_data(wr_data),
            .rd_en(bank_grant[b]), .rd_row(rd_row), .rd_repl(bank_repl[b]),
            .rd_q(bank_q[b])
        );
    end

    always_comb begin
        granted = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            granted = granted | bank_grant[b];
        end
    end

    logic [NUM_RD-1:0][BANK_W-1:0] bank_sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= '0;
            conflict <= 1'b0;
        end else begin
            rd_valid <= granted;
            conflict <= |(rd_en & ~granted);
        end
        bank_sel_q <= rd_bank;
    end

    always_comb begin
        for (int p = 0; p < int'(NUM_RD); p++) begin
            rd_data[p] = bank_q[bank_sel_q[p]][p];
        end
    end

    // R3
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid & ~$past(rd_en)) == '0);

    // R9
    conflict_on_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (conflict == (rd_valid != $past(rd_en))));
endmodule

// File: tb/tb_banked_repl_mem.sv
`timescale 1ns/1ps
module tb_banked_repl_mem;
    import bmem_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             wr_en = 1'b0;
    logic [5:0]       wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [3:0]       rd_en = '0;
    logic [3:0][5:0]  rd_addr = '0;
    logic [3:0]       v_td, v_sd;
    logic [3:0][7:0]  d_td, d_sd;
    logic             c_td, c_sd;

    banked_repl_mem dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v_td), .rd_data(d_td), .conflict(c_td)
    );

    banked_repl_mem #(.PORT_MODE(PORTS_SIMPLE_DUAL)) dut_sdp (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(v_sd), .rd_data(d_sd), .conflict(c_sd)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] shadow [64];

    function automatic logic [1:0] bank_of(input logic [5:0] a);
        return {a[4], a[1]};
    endfunction

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 5) & 8'hff);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge and check the results at the next falling edge.
    task automatic cycle(input string tag, input logic we, input logic [5:0] wa,
                         input logic [7:0] wd, input logic [3:0] en,
                         input logic [3:0][5:0] ra);
        logic [3:0] ev;
        int cnt [4];
        int cap;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = en; rd_addr = ra;
        @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 4; b++) cnt[b] = 0;
            ev = '0;
            for (int p = 0; p < 4; p++) begin
                if (m == 1) cap = 2;
                else cap = (we && bank_of(wa) == bank_of(ra[p])) ? 2 : 4;
                if (en[p] && cnt[bank_of(ra[p])] < cap) begin
                    ev[p] = 1'b1;
                    cnt[bank_of(ra[p])]++;
                end
            end
            chk(tag, m ? "sdp valid" : "tdp valid", m ? int'(v_sd) : int'(v_td), int'(ev));
            chk(tag, m ? "sdp conflict" : "tdp conflict",
                m ? int'(c_sd) : int'(c_td), int'(ev != en));
            for (int p = 0; p < 4; p++) begin
                if (ev[p] && (m ? v_sd[p] : v_td[p]))
                    chk(tag, m ? "sdp data" : "tdp data",
                        m ? int'(d_sd[p]) : int'(d_td[p]), int'(shadow[ra[p]]));
            end
        end
        if (we) shadow[wa] = wd;
        wr_en = 1'b0; rd_en = '0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        logic [3:0][5:0] ra;
        lcg = 32'h1234_5678;
        repeat (3) @(negedge clk);
        chk("R10", "reset valid", int'(v_td), 0);
        chk("R10", "reset conflict", int'(c_td), 0);
        rst = 1'b0;

        // R11, R2: fill every address through the write port
        for (int a = 0; a < 64; a++) cycle("R11", 1'b1, 6'(a), pattern(a), 4'b0, '0);

        // R2, R3: read every address alone on port 0
        for (int a = 0; a < 64; a++) cycle("R2", 1'b0, '0, '0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'(a)});

        // R6: four reads in one bank (rows differ via bit 0), no write: all served in tdp
        cycle("R6", 1'b0, '0, '0, 4'b1111, {6'd9, 6'd8, 6'd1, 6'd0});
        // R7: same load in sdp is capped at two (checked inside cycle)
        cycle("R7", 1'b0, '0, '0, 4'b1111, {6'd1, 6'd0, 6'd1, 6'd0});
        // R1: write to bank 1 (addr bit 1) leaves bank 0 at full capacity
        cycle("R1", 1'b1, 6'd2, 8'hA5, 4'b1111, {6'd0, 6'd0, 6'd0, 6'd0});
        // R1: addr bit 4 also selects the bank: reads split two banks
        cycle("R1", 1'b1, 6'd16, 8'h3C, 4'b1111, {6'd17, 6'd16, 6'd1, 6'd0});
        // R4, R8, R9: write hits the read address; ports 2,3 drop
        cycle("R4", 1'b1, 6'd0, 8'h5A, 4'b1111, {6'd0, 6'd0, 6'd0, 6'd0});
        // R5: four replicate-spread reads see the new word
        cycle("R5", 1'b0, '0, '0, 4'b1111, {6'd0, 6'd0, 6'd0, 6'd0});
        // R8: gaps in the request vector keep ascending priority
        cycle("R8", 1'b1, 6'd4, 8'h77, 4'b1101, {6'd8, 6'd4, 6'd0, 6'd0});
        // R9: no drop, conflict stays low
        cycle("R9", 1'b0, '0, '0, 4'b0011, {6'd0, 6'd0, 6'd2, 6'd0});

        // R6: pseudo-random sweep of reads and writes
        for (int i = 0; i < 400; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            for (int p = 0; p < 4; p++) ra[p] = 6'(lcg >> (6 * p + 2));
            cycle("R6", lcg[31], 6'(lcg >> 26), 8'(lcg >> 8), 4'(lcg >> 28), ra);
        end

        // R10: reset with reads pending clears flags and keeps storage
        rd_en = 4'b1111; rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "valid in reset", int'(v_td), 0);
        chk("R10", "conflict in reset", int'(c_td), 0);
        rst = 1'b0; rd_en = '0;
        for (int a = 0; a < 64; a += 5) cycle("R10", 1'b0, '0, '0, 4'b0001, {18'd0, 6'(a)});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule